// File: doc/BRIEF.md
# Two-Wire Master SCL Waveform Generator

This block produces the SCL line of a two-wire bus master from one system clock. A configuration word carries two 8-bit dividers and a 3-bit power-of-two prescale exponent. One divider sets the low phase and the other sets the high phase. Both share the exponent. Each phase lasts the divider shifted left by the exponent, plus four system clocks. Equal dividers therefore give a square wave.

While `enable` is high, the generator holds SCL low for the low phase and then releases it for the high phase, and it repeats this period. It emits four one-cycle strobes for a bit-level sequencer:
- one on the first cycle of each phase;
- one at the middle of the low phase, where SDA may change;
- one at the middle of the high phase, where SDA is sampled.

The configuration word is captured only when a new period starts. A change made part-way through a period therefore cannot shorten or stretch the phase in progress. Clearing `enable` releases SCL and clears all counting.

Top module: `scl_wave_gen`

## Requirements
- R1: The low phase lasts exactly (low_div << exp) + 4 system clocks. This is the count from the cycle `fall_stb` is high to the cycle `rise_stb` is high.
- R2: The high phase lasts exactly (high_div << exp) + 4 system clocks. This is the count from `rise_stb` to the next `fall_stb` of a continuing run.
- R3: The configuration word has three fields:
  - `cfg_word[7:0]` is low_div.
  - `cfg_word[15:8]` is high_div.
  - `cfg_word[18:16]` is exp, whose range is 0 to 7.
- R4: Equal low and high dividers give low and high phases of equal length.
- R5: The configuration is sampled only on the clock edge that starts a low phase. This is either the first edge with `enable` high after idle, or the edge that ends a high phase. Changes at any other time take effect only from the next period.
- R6: One clock edge after `enable` is sampled low, the block is idle: `scl_o` is 1, no strobe is asserted and the phase counter is zero, whatever `cfg_word` does. A later enable starts a fresh full-length low phase.
- R7: `change_stb` is high for one cycle, floor(L/2) cycles after `fall_stb`, where L is the low-phase length. `sample_stb` is high for one cycle, floor(H/2) cycles after `rise_stb`, where H is the high-phase length. At most one strobe is high in any cycle.
- R8: `fall_stb` is high only on the first cycle of a low phase, with `scl_o` = 0. `rise_stb` is high only on the first cycle of a high phase, with `scl_o` = 1.
- R9: With exp = 0 and both dividers 0, each phase lasts exactly 4 system clocks.
- R10: During and right after synchronous reset, `scl_o` is 1 and all strobes are 0.
- R11: When `enable` is raised from idle, `scl_o` goes low and `fall_stb` is asserted in the cycle after the first edge that samples `enable` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the SCL waveform while high |
| cfg_word | input | 19 | exp[18:16], high_div[15:8], low_div[7:0] |
| scl_o | output | 1 | SCL level: 0 drives low, 1 releases |
| fall_stb | output | 1 | First cycle of a low phase |
| change_stb | output | 1 | Middle of the low phase (SDA may change) |
| rise_stb | output | 1 | First cycle of a high phase |
| sample_stb | output | 1 | Middle of the high phase (SDA sampled) |

## Verification
A wrong phase counter or a stale length shows up at the ports as a strobe in the wrong cycle. The error is visible within the phase in which it occurs, at the latest on the next edge strobe. Each strobe is compared against an absolute expected cycle, so a single-cycle slip is caught at once.

A configuration loaded at the wrong moment shows up one period later, as a first phase whose length matches neither the old word nor the new one. The run that changes the word mid-period exposes this.

A counter left non-zero at disable shows up as a short first low phase after re-enable.

// File: rtl/scl_gen_pkg.sv
// Package: shared types for the SCL waveform generator.
// Assumes: nothing beyond IEEE 1800-2017.
package scl_gen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_cfg_hold.sv
// Module: scl_cfg_hold
// Holds the active configuration word. It captures the requested word only
// when the sequencer pulses `load`, so a running period never sees a change.
// Assumes: load is high for one cycle at the start of each period.
module scl_cfg_hold #(
    parameter int CFG_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_in,
    output logic [CFG_W-1:0] cfg_act
);
    // Capture the requested configuration at period boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_act <= '0;
        else if (load)
            cfg_act <= cfg_in;
    end
endmodule

// File: rtl/scl_phase_len.sv
// Module: scl_phase_len
// Computes one phase length, (div << shamt) + 4, and its midpoint.
// The shift is a staged barrel shifter, one stage per exponent bit.
// Assumes: LEN_W is wide enough for the largest shifted divider plus 4.
module scl_phase_len #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3,
    parameter int LEN_W = DIV_W + (1 << EXP_W)
) (
    input  logic [DIV_W-1:0] div,
    input  logic [EXP_W-1:0] shamt,
    output logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] mid
);
    logic [LEN_W-1:0] stage [EXP_W+1];

    assign stage[0] = LEN_W'(div);

    // One barrel stage per exponent bit: shift by 2^k when bit k is set.
    for (genvar k = 0; k < EXP_W; k++) begin : g_shift
        assign stage[k+1] = shamt[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    // Fixed four-cycle overhead, then halve for the strobe position.
    assign len = stage[EXP_W] + LEN_W'(4);
    assign mid = len >> 1;
endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Phase sequencer: idle, then low and high phases in turn, each counted to its
// length. It requests a configuration load at every period start. It drives a
// registered SCL level and decodes the four strobes from its state.
// Assumes: lengths are at least 4 and stay stable within a period.
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LEN_W-1:0] len_low,
    input  logic [LEN_W-1:0] len_high,
    input  logic [LEN_W-1:0] mid_low,
    input  logic [LEN_W-1:0] mid_high,
    output logic             load,
    output logic             scl_o,
    output logic             fall_stb,
    output logic             change_stb,
    output logic             rise_stb,
    output logic             sample_stb,
    output logic [LEN_W-1:0] cnt
);
    phase_e           phase, phase_nx;
    logic [LEN_W-1:0] cnt_nx;
    logic [LEN_W-1:0] cur_len;
    logic             last;
    logic             scl_q;

    // Length of the phase in progress and its final-cycle flag.
    always_comb begin
        cur_len = (phase == PH_HIGH) ? len_high : len_low;
        last    = (cnt == cur_len - LEN_W'(1));
    end

    // Next-state logic: disable forces idle; otherwise step or switch phase.
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt + LEN_W'(1);
        if (!enable) begin
            phase_nx = PH_IDLE;
            cnt_nx   = '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase_nx = PH_LOW;
                    cnt_nx   = '0;
                end
                PH_LOW: begin
                    if (last) begin
                        phase_nx = PH_HIGH;
                        cnt_nx   = '0;
                    end
                end
                PH_HIGH: begin
                    if (last) begin
                        phase_nx = PH_LOW;
                        cnt_nx   = '0;
                    end
                end
                default: begin
                    phase_nx = PH_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    // A new period begins on this edge: take the requested configuration.
    assign load = enable && ((phase == PH_IDLE) || ((phase == PH_HIGH) && last));

    // State, counter and SCL level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            scl_q <= 1'b1;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
            scl_q <= (phase_nx != PH_LOW);
        end
    end

    // Strobe decode from registered state only.
    always_comb begin
        scl_o      = scl_q;
        fall_stb   = (phase == PH_LOW)  && (cnt == '0);
        change_stb = (phase == PH_LOW)  && (cnt == mid_low);
        rise_stb   = (phase == PH_HIGH) && (cnt == '0);
        sample_stb = (phase == PH_HIGH) && (cnt == mid_high);
    end
endmodule

// File: rtl/scl_wave_gen.sv
// Module: scl_wave_gen (top)
// SCL waveform generator. A configuration hold register feeds two length
// units (low and high phase), and a sequencer counts the phases.
// Assumes: a single clock domain; enable and cfg_word are synchronous to clk.
module scl_wave_gen #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [2*DIV_W+EXP_W-1:0] cfg_word,
    output logic                     scl_o,
    output logic                     fall_stb,
    output logic                     change_stb,
    output logic                     rise_stb,
    output logic                     sample_stb
);
    localparam int CFG_W = 2 * DIV_W + EXP_W;
    localparam int LEN_W = DIV_W + (1 << EXP_W);

    logic [CFG_W-1:0] cfg_act;
    logic             cfg_load;
    logic [EXP_W-1:0] cfg_exp;
    logic [DIV_W-1:0] div_sel [2];
    logic [LEN_W-1:0] len_sel [2];
    logic [LEN_W-1:0] mid_sel [2];
    logic [LEN_W-1:0] seq_cnt;

    scl_cfg_hold #(.CFG_W(CFG_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cfg_load),
        .cfg_in  (cfg_word),
        .cfg_act (cfg_act)
    );

    // Field split: index 0 is the low phase, index 1 is the high phase.
    assign div_sel[0] = cfg_act[DIV_W-1:0];
    assign div_sel[1] = cfg_act[2*DIV_W-1:DIV_W];
    assign cfg_exp    = cfg_act[CFG_W-1:2*DIV_W];

    // One length unit per phase; both share the exponent.
    for (genvar g = 0; g < 2; g++) begin : g_len
        scl_phase_len #(.DIV_W(DIV_W), .EXP_W(EXP_W), .LEN_W(LEN_W)) u_len (
            .div   (div_sel[g]),
            .shamt (cfg_exp),
            .len   (len_sel[g]),
            .mid   (mid_sel[g])
        );
    end

    scl_phase_seq #(.LEN_W(LEN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .len_low    (len_sel[0]),
        .len_high   (len_sel[1]),
        .mid_low    (mid_sel[0]),
        .mid_high   (mid_sel[1]),
        .load       (cfg_load),
        .scl_o      (scl_o),
        .fall_stb   (fall_stb),
        .change_stb (change_stb),
        .rise_stb   (rise_stb),
        .sample_stb (sample_stb),
        .cnt        (seq_cnt)
    );
endmodule

// File: rtl/scl_wave_gen_chk.sv
// Module: scl_wave_gen_chk
// Property checker bound into scl_wave_gen. It times each phase with its own
// counters and compares the result against lengths decoded from the active
// configuration.
// Assumes: bound with the same parameters as the top.
module scl_wave_gen_chk #(
    parameter int DIV_W = 8,
    parameter int EXP_W = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       enable,
    input logic                       scl_o,
    input logic                       fall_stb,
    input logic                       change_stb,
    input logic                       rise_stb,
    input logic                       sample_stb,
    input logic [2*DIV_W+EXP_W-1:0]   cfg_act,
    input logic [DIV_W+(1<<EXP_W)-1:0] cnt
);
    localparam int RUN_W = DIV_W + (1 << EXP_W) + 1;

    logic [RUN_W-1:0] want_low, want_high, low_run, high_run;

    // Expected phase lengths from the active configuration fields.
    assign want_low  = (RUN_W'(cfg_act[DIV_W-1:0]) << cfg_act[2*DIV_W+EXP_W-1:2*DIV_W]) + RUN_W'(4);
    assign want_high = (RUN_W'(cfg_act[2*DIV_W-1:DIV_W]) << cfg_act[2*DIV_W+EXP_W-1:2*DIV_W]) + RUN_W'(4);

    // Count consecutive low cycles of SCL.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_run <= '0;
        else if (!scl_o) low_run <= low_run + RUN_W'(1);
        else             low_run <= '0;
    end

    // Count high cycles since the last rise strobe; cleared while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)      high_run <= '0;
        else if (rise_stb)          high_run <= RUN_W'(1);
        else if (scl_o && high_run != '0) high_run <= high_run + RUN_W'(1);
        else                        high_run <= '0;
    end

    assert_low_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> (low_run == want_low));

    assert_high_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_stb && high_run != '0) |-> (high_run == $past(want_high)));

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_stb |-> $stable(cfg_act));

    assert_idle_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (scl_o && cnt == '0));

    assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_stb, change_stb, rise_stb, sample_stb}));

    assert_fall_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> !scl_o);

    assert_rise_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> scl_o);
endmodule

bind scl_wave_gen scl_wave_gen_chk #(.DIV_W(DIV_W), .EXP_W(EXP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .scl_o      (scl_o),
    .fall_stb   (fall_stb),
    .change_stb (change_stb),
    .rise_stb   (rise_stb),
    .sample_stb (sample_stb),
    .cfg_act    (cfg_act),
    .cnt        (seq_cnt)
);

// File: tb/scl_wave_gen_test.sv
`timescale 1ns/1ps
module scl_wave_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [18:0] cfg_word = '0;
    logic        scl_o, fall_stb, change_stb, rise_stb, sample_stb;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int exp_kind_q[$];
    int exp_cyc_q[$];

    scl_wave_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_word(cfg_word),
        .scl_o(scl_o), .fall_stb(fall_stb), .change_stb(change_stb),
        .rise_stb(rise_stb), .sample_stb(sample_stb)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // R3: exp in [18:16], high_div in [15:8], low_div in [7:0]
    function automatic logic [18:0] make_cfg(input int e, input int hi, input int lo);
        return {e[2:0], hi[7:0], lo[7:0]};
    endfunction

    function automatic int plen(input int dv, input int e);
        return dv * (1 << e) + 4;
    endfunction

    // Driver side: expected events of one period (0 fall, 1 change, 2 rise, 3 sample).
    function automatic void push_period(input int base, input int l, input int h);
        exp_kind_q.push_back(0); exp_cyc_q.push_back(base);
        exp_kind_q.push_back(1); exp_cyc_q.push_back(base + l / 2);
        exp_kind_q.push_back(2); exp_cyc_q.push_back(base + l);
        exp_kind_q.push_back(3); exp_cyc_q.push_back(base + l + h / 2);
    endfunction

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: pop and compare each strobe as the design produces it.
    always @(negedge clk) begin : mon
        int ns, k, ek, ec;
        string tag;
        if (rst_n && !done) begin
            ns = int'(fall_stb) + int'(change_stb) + int'(rise_stb) + int'(sample_stb);
            if (ns > 1) chk(1'b0, "R7", ns, 1, "strobes in one cycle");
            if (ns == 1) begin
                k = fall_stb ? 0 : change_stb ? 1 : rise_stb ? 2 : 3;
                tag = (k == 0) ? "R2" : (k == 2) ? "R1" : "R7";
                if (exp_kind_q.size() == 0) begin
                    chk(1'b0, "R6", k, -1, "unexpected strobe kind");
                end else begin
                    ek = exp_kind_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    chk(k == ek, tag, k, ek, "strobe kind");
                    chk(cyc == ec, tag, cyc, ec, "strobe cycle");
                    chk(scl_o == (k >= 2), "R8", scl_o, (k >= 2), "scl level at strobe");
                end
            end
        end
    end

    // Run n periods: the first uses ca, and cb is presented at mid-low of period one.
    task automatic run_seq(input logic [18:0] ca, input int la, input int ha,
                           input logic [18:0] cb, input int lb, input int hb, input int n);
        int base, nxt, last_smp;
        cfg_word = ca;
        enable   = 1'b1;
        base     = cyc + 1;
        push_period(base, la, ha);
        last_smp = base + la + ha / 2;
        nxt      = base + la + ha;
        for (int p = 1; p < n; p++) begin
            push_period(nxt, lb, hb);   // R5: new word only from the next period
            last_smp = nxt + lb + hb / 2;
            nxt      = nxt + lb + hb;
        end
        @(negedge clk);
        chk(scl_o == 1'b0, "R11", scl_o, 0, "scl one cycle after enable");
        wait_cyc(base + la / 2);
        cfg_word = cb;
        wait_cyc(last_smp);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_o == 1'b1, "R6", scl_o, 1, "scl released after disable");
        @(negedge clk);
        chk(exp_kind_q.size() == 0, "R5", exp_kind_q.size(), 0, "expected events left");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        // R10: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cfg_word = make_cfg(i, i, i);
            enable   = (i == 2);
            chk(scl_o == 1'b1, "R10", scl_o, 1, "scl in reset");
            chk({fall_stb, change_stb, rise_stb, sample_stb} == 4'b0, "R10",
                {fall_stb, change_stb, rise_stb, sample_stb}, 0, "strobes in reset");
        end
        enable = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(scl_o == 1'b1, "R10", scl_o, 1, "scl after reset");

        // R9: all-zero word gives four-cycle phases
        run_seq(make_cfg(0, 0, 0), 4, 4, make_cfg(0, 0, 0), 4, 4, 3);
        // R5/R4: switch mid-period to equal dividers (exp 1, div 7 -> 18 each)
        run_seq(make_cfg(2, 5, 3), plen(3, 2), plen(5, 2),
                make_cfg(1, 7, 7), plen(7, 1), plen(7, 1), 3);
        // R3: largest exponent field
        run_seq(make_cfg(7, 2, 1), plen(1, 7), plen(2, 7),
                make_cfg(7, 2, 1), plen(1, 7), plen(2, 7), 2);
        // R3: full high byte, zero low byte
        run_seq(make_cfg(3, 255, 0), plen(0, 3), plen(255, 3),
                make_cfg(0, 0, 0), 4, 4, 1);

        // R6: disable mid-low, hold idle while the word changes, then restart
        @(negedge clk);
        cfg_word = make_cfg(1, 3, 3);
        enable   = 1'b1;
        base     = cyc + 1;
        exp_kind_q.push_back(0); exp_cyc_q.push_back(base);
        exp_kind_q.push_back(1); exp_cyc_q.push_back(base + plen(3, 1) / 2);
        wait_cyc(base + plen(3, 1) / 2);
        enable = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(scl_o == 1'b1, "R6", scl_o, 1, "scl while disabled");
            cfg_word = make_cfg(i, 9 + i, 2 * i);
        end
        chk(exp_kind_q.size() == 0, "R6", exp_kind_q.size(), 0, "events after disable");
        run_seq(make_cfg(1, 3, 3), plen(3, 1), plen(3, 1),
                make_cfg(1, 3, 3), plen(3, 1), plen(3, 1), 2);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule